// File: doc/BRIEF.md
# Credit-Gated Wormhole Input Port Controller

This block is the receive side of one port of a wormhole router. Flits arrive from the neighbouring router and are written into a small local queue. Every flit that leaves the queue sends a one-cycle credit pulse back upstream, so the sender always knows how many slots are free. When a packet's first flit reaches the head of the queue and the routing logic reports the destination as resolved, the controller raises a request to the switch allocator. After the grant, it streams the whole packet, from its first flit to its last, toward the crossbar.

Inbound flow control is by credit, not by ready. The sender may drive `in_valid` only while it holds a credit. There is no ready signal. A flit offered while the queue is full is dropped and `err_ovf` is raised. On the outbound side, `out_valid` is the flit request toward the crossbar, and the downstream credit counter applies the back-pressure. A flit goes out only in a cycle where that counter is non-zero. The downstream router returns each freed slot as a pulse on `credit_dn`. `out_data`, `out_bop` and `out_eop` are meaningful only while `out_valid` is high.

The controller has three states: idle, waiting for a grant, and forwarding. Leaving the forwarding state happens only on the end-of-packet flit, so the granted channel is held for the full packet.

Top module: `wh_in_port`

## Requirements
- R1: After reset the queue is empty, the controller is idle, the downstream credit count equals DN_DEPTH (default 4), and `out_valid`, `alloc_req`, `credit_up` and `err_ovf` are all low.
- R2: The queue holds up to DEPTH (default 4) flits of W (default 32) data bits plus the begin and end marks, and delivers them in arrival order. A write is accepted when the queue is not full, or when it is full and a flit leaves in the same cycle.
- R3: If `in_valid` is high while the queue holds DEPTH flits and none leaves in that cycle, `err_ovf` is high in that same cycle and the flit is discarded.
- R4: `credit_up` is high for exactly those cycles in which a flit leaves the queue, whether it is forwarded or discarded.
- R5: `alloc_req` rises in the cycle after an idle controller sees a begin-of-packet flit at the queue head while `route_ready` is high. It stays high until the end-of-packet flit is forwarded. While `route_ready` is low, an idle controller does not request.
- R6: No flit is forwarded before a grant. `alloc_grant` is sampled only while waiting, and the forwarding state starts the cycle after it is seen.
- R7: In the forwarding state, `out_valid` is high in every cycle where the queue is non-empty and the credit count is non-zero. In those cycles, `out_data`, `out_bop` and `out_eop` equal the head flit.
- R8: The credit count drops by one per forwarded flit and rises by one per `credit_dn` pulse (no change when both occur in the same cycle). A pulse that would take it above DN_DEPTH is ignored. With no returns, at most DN_DEPTH flits are forwarded.
- R9: Forwarding the end-of-packet flit returns the controller to idle in the next cycle. The next packet needs a fresh request and grant.
- R10: A flit without the begin mark found at the queue head while idle is discarded: it is not forwarded, and a credit pulse is returned for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream flit strobe (credit-governed) |
| in_data | input | W | Upstream flit payload |
| in_bop | input | 1 | Upstream flit is first of packet |
| in_eop | input | 1 | Upstream flit is last of packet |
| credit_up | output | 1 | One-cycle credit returned upstream |
| err_ovf | output | 1 | Write into full queue (protocol error) |
| route_ready | input | 1 | Destination of head packet resolved |
| alloc_req | output | 1 | Output request to the switch allocator |
| alloc_grant | input | 1 | Grant from the switch allocator |
| out_valid | output | 1 | Flit request toward the crossbar |
| out_data | output | W | Forwarded flit payload |
| out_bop | output | 1 | Forwarded flit is first of packet |
| out_eop | output | 1 | Forwarded flit is last of packet |
| credit_dn | input | 1 | Credit returned by the downstream router |

## Verification
The bench exhausts downstream credit in the middle of a packet. A counter that wrapped or failed to block would send a fifth flit into a full neighbour. It also returns a credit while the counter is already full, which a design without a clamp would turn into a phantom extra slot. It writes into a full queue while `route_ready` is held low: a design that overwrote the queue instead of dropping the flit would later forward the wrong data or too many flits. It also keeps the grant low while a request is pending, and offers a headless body flit and a one-flit packet. A design that held the channel past the end mark, forwarded before the grant, or stalled on a stray flit would show a mismatch in `out_valid`, `alloc_req` or `credit_up` in the very cycle of the error.

// File: rtl/wh_port_pkg.sv
package wh_port_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_FWD  = 2'd2
  } port_st_e;
endpackage

// File: rtl/wh_flit_queue.sv
module wh_flit_queue #(
  parameter int W     = 34,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_req,
  input  logic [W-1:0] wr_data,
  input  logic         rd,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full,
  output logic         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          wr;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign ovf     = wr_req && full && !rd;
  assign wr      = wr_req && !ovf;
  assign rd_data = slots[rp];

  always_ff @(posedge clk) begin
    if (wr) slots[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      cnt <= cnt + CW'(wr) - CW'(rd);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R2
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && full && !rd) |=> full); // R3
endmodule

// File: rtl/wh_credit_ctr.sv
module wh_credit_ctr #(
  parameter int MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic give,
  output logic avail
);
  localparam int CW = $clog2(MAX + 1);

  logic [CW-1:0] cnt;
  logic          give_ok;

  assign give_ok = give && ((cnt != CW'(MAX)) || take);
  assign avail   = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= CW'(MAX);
    else        cnt <= cnt + CW'(give_ok) - CW'(take);
  end

  AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAX)); // R8
  AST_TAKE_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (cnt != '0)); // R8
endmodule

// File: rtl/wh_port_fsm.sv
module wh_port_fsm
  import wh_port_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic head_valid,
  input  logic head_bop,
  input  logic head_eop,
  input  logic route_ready,
  input  logic grant,
  input  logic has_credit,
  output logic send,
  output logic drop,
  output logic req
);
  port_st_e st, st_nx;

  assign send = (st == ST_FWD) && head_valid && has_credit;
  assign drop = (st == ST_IDLE) && head_valid && !head_bop;
  assign req  = (st != ST_IDLE);

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (head_valid && head_bop && route_ready) st_nx = ST_WAIT;
      ST_WAIT: if (grant) st_nx = ST_FWD;
      ST_FWD:  if (send && head_eop) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end
endmodule

// File: rtl/wh_in_port.sv
module wh_in_port #(
  parameter int W        = 32,
  parameter int DEPTH    = 4,
  parameter int DN_DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         in_bop,
  input  logic         in_eop,
  output logic         credit_up,
  output logic         err_ovf,
  input  logic         route_ready,
  output logic         alloc_req,
  input  logic         alloc_grant,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_bop,
  output logic         out_eop,
  input  logic         credit_dn
);
  localparam int FW = W + 2;

  logic [FW-1:0] head;
  logic          q_empty, q_full, q_rd;
  logic          has_credit, send, drop;

  wh_flit_queue #(.W(FW), .DEPTH(DEPTH)) u_q (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (in_valid),
    .wr_data ({in_bop, in_eop, in_data}),
    .rd      (q_rd),
    .rd_data (head),
    .empty   (q_empty),
    .full    (q_full),
    .ovf     (err_ovf)
  );

  wh_credit_ctr #(.MAX(DN_DEPTH)) u_cr (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (send),
    .give  (credit_dn),
    .avail (has_credit)
  );

  wh_port_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .head_valid  (!q_empty),
    .head_bop    (head[FW-1]),
    .head_eop    (head[FW-2]),
    .route_ready (route_ready),
    .grant       (alloc_grant),
    .has_credit  (has_credit),
    .send        (send),
    .drop        (drop),
    .req         (alloc_req)
  );

  assign q_rd      = send || drop;
  assign credit_up = q_rd;
  assign out_valid = send;
  assign out_data  = head[W-1:0];
  assign out_bop   = head[FW-1];
  assign out_eop   = head[FW-2];

  AST_FWD_UNDER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> alloc_req); // R6
  AST_EOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eop) |=> !alloc_req); // R9
  AST_NO_ERR_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
    credit_up |-> !err_ovf); // R3
endmodule

// File: tb/sim_wh_in_port.sv
module sim_wh_in_port;
  localparam int W = 32, DEPTH = 4, DN = 4;

  logic clk = 0, rst_n = 0;
  logic iv = 0, ib = 0, ie = 0, rr = 0, gr = 0, cd = 0;
  logic [W-1:0] id = '0;
  logic credit_up, err_ovf, alloc_req, out_valid, out_bop, out_eop;
  logic [W-1:0] out_data;

  always #4 clk = ~clk;

  wh_in_port #(.W(W), .DEPTH(DEPTH), .DN_DEPTH(DN)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(iv), .in_data(id), .in_bop(ib),
    .in_eop(ie), .credit_up(credit_up), .err_ovf(err_ovf),
    .route_ready(rr), .alloc_req(alloc_req), .alloc_grant(gr),
    .out_valid(out_valid), .out_data(out_data), .out_bop(out_bop),
    .out_eop(out_eop), .credit_dn(cd)
  );

  int n_chk = 0, n_fail = 0;
  int n_sent = 0, n_cup = 0, n_err = 0;
  bit cd_auto = 0, last_send = 0, done = 0;
  logic [W+1:0] q[$];
  int st = 0, cr = DN;

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    logic [W+1:0] h;
    bit send, drop, pop, req, err;
    if (cd_auto) cd = last_send;
    #1;
    h    = (q.size() > 0) ? q[0] : '0;
    send = (st == 2) && (q.size() > 0) && (cr > 0);
    drop = (st == 0) && (q.size() > 0) && !h[W+1];
    pop  = send || drop;
    req  = (st != 0);
    err  = iv && (q.size() == DEPTH) && !pop;
    check(out_valid == send, "R7 out_valid", out_valid, send);
    if (send) begin
      check(out_data == h[W-1:0], "R7 out_data", out_data, h[W-1:0]);
      check({out_bop, out_eop} == h[W+1:W], "R7 marks", {out_bop, out_eop}, h[W+1:W]);
    end
    check(alloc_req == req, "R5 alloc_req", alloc_req, req);
    check(credit_up == pop, "R4 credit_up", credit_up, pop);
    check(err_ovf == err, "R3 err_ovf", err_ovf, err);
    if (out_valid) n_sent++;
    if (credit_up) n_cup++;
    if (err_ovf) n_err++;
    @(posedge clk);
    case (st)
      0: if (q.size() > 0 && h[W+1] && rr) st = 1;
      1: if (gr) st = 2;
      2: if (send && h[W]) st = 0;
      default: st = 0;
    endcase
    if (pop) void'(q.pop_front());
    if (iv && !err) q.push_back({ib, ie, id});
    cr = cr - int'(send) + int'(cd);
    if (cr > DN) cr = DN;
    last_send = send;
    @(negedge clk);
  endtask

  task automatic push(bit b, bit e, logic [W-1:0] d);
    iv = 1; ib = b; ie = e; id = d;
    step();
    iv = 0; ib = 0; ie = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int base, cbase;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    check(!out_valid && !alloc_req && !credit_up && !err_ovf, "R1 reset outputs",
          {out_valid, alloc_req, credit_up, err_ovf}, 0);
    idle(2);

    // Multi-flit packet, grant always on
    rr = 1; gr = 1; cd_auto = 1;
    base = n_sent;
    push(1, 0, 32'hA000_0001);
    push(0, 0, 32'hA000_0002);
    push(0, 1, 32'hA000_0003);
    idle(8);
    check(n_sent - base == 3, "R7 packet flits forwarded", n_sent - base, 3);
    check(alloc_req == 0, "R9 idle after eop", alloc_req, 0);

    // R6: grant withheld
    gr = 0; base = n_sent;
    push(1, 1, 32'hB000_0001);
    idle(5);
    check(n_sent - base == 0, "R6 no forward before grant", n_sent - base, 0);
    check(alloc_req == 1, "R5 request held while waiting", alloc_req, 1);
    gr = 1;
    idle(4);
    check(n_sent - base == 1, "R9 single-flit packet done", n_sent - base, 1);

    // R3/R5: route not ready, queue fills and overflows
    rr = 0; base = n_sent; n_err = 0;
    push(1, 0, 32'hC000_0001);
    push(0, 0, 32'hC000_0002);
    push(0, 0, 32'hC000_0003);
    push(0, 1, 32'hC000_0004);
    push(1, 1, 32'hC0DE_DEAD);
    check(n_err == 1, "R3 overflow flagged once", n_err, 1);
    idle(3);
    check(alloc_req == 0, "R5 no request without route_ready", alloc_req, 0);
    rr = 1;
    idle(10);
    check(n_sent - base == 4, "R2 dropped flit not forwarded", n_sent - base, 4);

    // R8: credit at full ignored, then starvation
    cd_auto = 0; cd = 1; step(); cd = 0;
    base = n_sent;
    push(1, 0, 32'hD000_0001);
    push(0, 0, 32'hD000_0002);
    push(0, 0, 32'hD000_0003);
    push(0, 0, 32'hD000_0004);
    push(0, 0, 32'hD000_0005);
    push(0, 1, 32'hD000_0006);
    idle(5);
    check(n_sent - base == 4, "R8 forwarding stops at zero credit", n_sent - base, 4);
    check(alloc_req == 1, "R9 channel held mid-packet", alloc_req, 1);
    cd = 1; idle(2); cd = 0;
    idle(4);
    check(n_sent - base == 6, "R8 returned credits resume", n_sent - base, 6);
    check(alloc_req == 0, "R9 released after eop", alloc_req, 0);
    cd = 1; idle(4); cd = 0;

    // R10: headless flit discarded
    cd_auto = 1; base = n_sent; cbase = n_cup;
    push(0, 0, 32'hE000_0001);
    idle(3);
    check(n_sent - base == 0, "R10 stray flit not forwarded", n_sent - base, 0);
    check(n_cup - cbase == 1, "R10 stray flit credited", n_cup - cbase, 1);

    // Random traffic against the model
    for (int i = 0; i < 400; i++) begin
      iv = ($urandom % 3) == 0; ib = $urandom % 2; ie = $urandom % 2;
      id = $urandom; rr = ($urandom % 4) != 0; gr = $urandom % 2;
      step();
    end
    iv = 0;
    idle(20);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule